// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Generator

This block sits between a synchronous host and a fast-page-style asynchronous DRAM with two byte lanes. It takes one request at a time and turns it into a complete memory cycle. A request is a read, an early write or a read-modify-write, and it carries a word address and a byte-enable pair. The block drives the row address and then the column address on a multiplexed address bus. It strobes the row and column lines and the write line in the order and with the spacing that the cycle type needs. When the cycle includes a read, it returns the word it read on a one-cycle result strobe.

Every analogue timing limit is a parameter counted in clock cycles. These cover row setup and hold, column setup, the three access times, write setup ahead of the column strobe, the three delays a read-modify-write must satisfy before its write strobe, write lead ahead of the column strobe release, and row and column precharge. From these the block derives the length of each phase at elaboration time. Both lane strobes fall and rise together, so the earlier and later lane edges are the same edge. The block also reports when the memory is expected to drive the data bus (`dram_oe`) and when the controller drives write data (`dq_drive`), so that a board-level bus can stay free of contention.

Request kinds are encoded on `req_kind` as 2'b00 read, 2'b01 early write and 2'b10 read-modify-write. The code 2'b11 behaves as a read. Host address bits `[ROW_W+COL_W-1:COL_W]` form the row and `[COL_W-1:0]` form the column. Bit `i` of `req_be` governs `cas_n[i]` and data bits `[8i+7:8i]`.

Top module: `dram_cycle_gen`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `ras_n`, every `cas_n` bit and `we_n` are 1, `dram_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: The column address is on `dram_addr` for at least T_ASC cycles before the column strobe falls, and it does not change while any `cas_n` bit is low. `cas_n` is never low while `ras_n` is high.
- R3: Read data is sampled only after the column strobe has been low for at least T_CAC cycles, the row strobe for at least T_RAC cycles and the column address for at least T_AA cycles. Each read or read-modify-write request produces exactly one single-cycle `rd_valid` pulse.
- R4: In an early write (kind 2'b01), `we_n` is low for at least T_WCS cycles before the column strobe falls, `dq_drive` is high while the strobe is low, and `dram_oe` stays 0 for the whole cycle.
- R5: In a read-modify-write (kind 2'b10), `we_n` falls only after the column strobe has been low for at least T_CWD cycles, the row strobe for at least T_RWD cycles and the column address for at least T_AWD cycles. `rd_data` returns the contents held before the write.
- R6: `we_n` has been low for at least T_CWL cycles when the column strobe rises in every write or read-modify-write cycle.
- R7: In a read cycle `we_n` stays high from acceptance until the row strobe rises.
- R8: `dram_oe` is 1 only while `ras_n` is low and at least one `cas_n` bit is low. It falls in the same cycle in which the last of those strobes rises.
- R9: `ras_n` stays high for at least T_RP cycles between row cycles, and the column strobes stay high for at least T_CP cycles between column cycles.
- R10: Lane `i` strobes `cas_n[i]` only when `req_be[i]` was 1. A read returns 0 in disabled byte lanes, and a write leaves disabled bytes unchanged.
- R11: A request with `req_be` = 2'b00 completes without any `cas_n` bit going low. A read of this kind returns `rd_data` = 0.
- R12: A request is accepted only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 00 read, 01 early write, 10 read-modify-write |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_be | input | LANES | Byte-lane enables |
| req_wdata | input | 8*LANES | Write data |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| rd_data | output | 8*LANES | Word read, disabled lanes zero |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | LANES | Per-lane column strobes, active low |
| we_n | output | 1 | Write strobe, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | 8*LANES | Write data toward the memory |
| dq_drive | output | 1 | Controller drives `dq_out` onto the bus |
| dq_in | input | 8*LANES | Data from the memory |
| dram_oe | output | 1 | Memory expected to drive the data bus |

## Verification
The bench builds the block with 4-bit rows and columns and T_ASC = 2, T_RAH = 1, T_RAC = 6, T_RWD = 7 and T_RP = 3. With these values the RAS access time sets the read sample point and the RAS-to-WE delay sets the read-modify-write strobe, each with no spare cycle. A one-cycle shortening of either phase then returns bad data or trips a delay check. A memory model in the bench returns valid data only once all three access windows have elapsed. The small address space lets the model hold the whole array, so partial-lane writes and the old data returned by read-modify-write are checked by reading back.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_RMW   = 2'b10,
    K_ALTRD = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ROWSU, S_RASLO, S_COLSU, S_CASLO, S_WRLO, S_PRE
  } state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dcg_timer.sv
module dcg_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/dcg_lane.sv
module dcg_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [7:0] wr_in,
  input  logic       cas_act_nxt,
  input  logic       be_nxt,
  input  logic       cap_nxt,
  input  logic [7:0] dq_byte,
  output logic       cas_n,
  output logic [7:0] wr_byte,
  output logic [7:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cas_n   <= 1'b1;
      wr_byte <= '0;
      rd_byte <= '0;
    end else begin
      cas_n <= !(cas_act_nxt && be_nxt);
      if (accept)  wr_byte <= wr_in;
      if (cap_nxt) rd_byte <= be_nxt ? dq_byte : 8'h00;
    end
  end

  // R10: write data on this lane holds while its strobe is low
  p_wdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && $past(!cas_n)) |-> $stable(wr_byte));
endmodule

// File: rtl/dcg_seq.sv
module dcg_seq
  import dcg_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int AP_W    = 10,
  parameter int LANES   = 2,
  parameter int CNT_W   = 4,
  parameter int L_ROWSU = 1,
  parameter int L_RAH   = 1,
  parameter int L_COL   = 1,
  parameter int L_ACC   = 1,
  parameter int L_WED   = 1,
  parameter int L_CWL   = 1,
  parameter int L_PRE   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic             accept,
  output logic             ras_n,
  output logic             we_n,
  output logic [AP_W-1:0]  addr_o,
  output logic             dram_oe,
  output logic             dq_drive,
  output logic             rd_valid,
  output logic             cas_act_nxt,
  output logic             cap_nxt,
  output logic [LANES-1:0] be_nxt
);
  state_e state_q, state_n;
  kind_e  kind_q, cur_kind;
  logic [ROW_W-1:0] row_q, cur_row;
  logic [COL_W-1:0] col_q, cur_col;
  logic [LANES-1:0] be_q;
  logic             done, load, wr_phase, col_phase, ras_phase;
  logic [CNT_W-1:0] load_val;
  int               dur_n;

  dcg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(done)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign cur_kind  = accept ? kind_e'(req_kind) : kind_q;
  assign cur_row   = accept ? req_row : row_q;
  assign cur_col   = accept ? req_col : col_q;
  assign be_nxt    = accept ? req_be  : be_q;

  always_comb begin
    state_n = state_q;
    case (state_q)
      S_IDLE:  if (req_valid) state_n = S_ROWSU;
      S_ROWSU: if (done) state_n = S_RASLO;
      S_RASLO: if (done) state_n = S_COLSU;
      S_COLSU: if (done) state_n = S_CASLO;
      S_CASLO: if (done) state_n = (kind_q == K_RMW) ? S_WRLO : S_PRE;
      S_WRLO:  if (done) state_n = S_PRE;
      S_PRE:   if (done) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_comb begin
    case (state_n)
      S_ROWSU: dur_n = L_ROWSU;
      S_RASLO: dur_n = L_RAH;
      S_COLSU: dur_n = L_COL;
      S_CASLO: dur_n = (cur_kind == K_WRITE) ? L_CWL :
                       (cur_kind == K_RMW)   ? L_WED : L_ACC;
      S_WRLO:  dur_n = L_CWL;
      S_PRE:   dur_n = L_PRE;
      default: dur_n = 1;
    endcase
  end

  assign load     = (state_n != state_q);
  assign load_val = CNT_W'(dur_n - 1);
  assign cap_nxt  = (state_q == S_CASLO) && done && (kind_q != K_WRITE);

  assign ras_phase   = state_n inside {S_RASLO, S_COLSU, S_CASLO, S_WRLO};
  assign col_phase   = state_n inside {S_COLSU, S_CASLO, S_WRLO};
  assign cas_act_nxt = state_n inside {S_CASLO, S_WRLO};
  assign wr_phase    = (state_n == S_WRLO) ||
                       ((state_n inside {S_COLSU, S_CASLO}) && cur_kind == K_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      kind_q   <= K_READ;
      row_q    <= '0;
      col_q    <= '0;
      be_q     <= '0;
      ras_n    <= 1'b1;
      we_n     <= 1'b1;
      addr_o   <= '0;
      dram_oe  <= 1'b0;
      dq_drive <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      state_q <= state_n;
      if (accept) begin
        kind_q <= cur_kind;
        row_q  <= req_row;
        col_q  <= req_col;
        be_q   <= req_be;
      end
      ras_n    <= !ras_phase;
      addr_o   <= col_phase ? AP_W'(cur_col) : AP_W'(cur_row);
      we_n     <= !wr_phase;
      dq_drive <= wr_phase;
      dram_oe  <= (state_n == S_CASLO) && (cur_kind != K_WRITE) && (|be_nxt);
      rd_valid <= cap_nxt;
    end
  end

  // R4: an early write never lets the memory drive the bus
  p_wr_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_WRITE && state_q != S_IDLE) |-> !dram_oe);
  // R7: a read cycle keeps the write strobe high
  p_read_we_high_r7: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_READ && state_q != S_IDLE) |-> we_n);
  // R3: the result strobe lasts a single cycle
  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/dram_cycle_gen.sv
module dram_cycle_gen
  import dcg_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int LANES = 2,
  parameter int T_ASR = 1,
  parameter int T_RAH = 2,
  parameter int T_ASC = 1,
  parameter int T_WCS = 1,
  parameter int T_CAC = 2,
  parameter int T_AA  = 3,
  parameter int T_RAC = 6,
  parameter int T_CWD = 3,
  parameter int T_RWD = 7,
  parameter int T_AWD = 5,
  parameter int T_CWL = 2,
  parameter int T_RP  = 5,
  parameter int T_CP  = 1,
  localparam int AP_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int DQ_W = 8 * LANES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_kind,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LANES-1:0]       req_be,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  output logic                   ras_n,
  output logic [LANES-1:0]       cas_n,
  output logic                   we_n,
  output logic [AP_W-1:0]        dram_addr,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_drive,
  input  logic [DQ_W-1:0]        dq_in,
  output logic                   dram_oe
);
  localparam int L_ROWSU = imax(T_ASR, 1);
  localparam int L_RAH   = imax(T_RAH, 1);
  localparam int L_COL   = imax(imax(T_ASC, T_WCS), 1);
  localparam int L_ACC   = imax(imax(T_CAC, T_AA - L_COL),
                                imax(T_RAC - L_RAH - L_COL, 1));
  localparam int L_WED   = imax(imax(L_ACC, T_CWD),
                                imax(T_RWD - L_RAH - L_COL, T_AWD - L_COL));
  localparam int L_CWL   = imax(T_CWL, 1);
  localparam int L_PRE   = imax(imax(T_RP, T_CP), 1);
  localparam int L_MAX   = imax(imax(imax(L_ROWSU, L_RAH), imax(L_COL, L_WED)),
                                imax(L_CWL, L_PRE));
  localparam int CNT_W   = $clog2(L_MAX + 1);

  logic             accept, cas_act_nxt, cap_nxt;
  logic [LANES-1:0] be_nxt;

  dcg_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .AP_W(AP_W), .LANES(LANES), .CNT_W(CNT_W),
    .L_ROWSU(L_ROWSU), .L_RAH(L_RAH), .L_COL(L_COL), .L_ACC(L_ACC),
    .L_WED(L_WED), .L_CWL(L_CWL), .L_PRE(L_PRE)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_row(req_addr[ROW_W+COL_W-1:COL_W]), .req_col(req_addr[COL_W-1:0]),
    .req_be(req_be), .req_ready(req_ready), .accept(accept), .ras_n(ras_n),
    .we_n(we_n), .addr_o(dram_addr), .dram_oe(dram_oe), .dq_drive(dq_drive),
    .rd_valid(rd_valid), .cas_act_nxt(cas_act_nxt), .cap_nxt(cap_nxt),
    .be_nxt(be_nxt)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dcg_lane u_lane (
      .clk(clk), .rst(rst), .accept(accept), .wr_in(req_wdata[8*i +: 8]),
      .cas_act_nxt(cas_act_nxt), .be_nxt(be_nxt[i]), .cap_nxt(cap_nxt),
      .dq_byte(dq_in[8*i +: 8]), .cas_n(cas_n[i]),
      .wr_byte(dq_out[8*i +: 8]), .rd_byte(rd_data[8*i +: 8])
    );
  end

  // R8: the memory may drive only while both strobe groups are active
  p_oe_strobes_r8: assert property (@(posedge clk) disable iff (rst)
    dram_oe |-> (!ras_n && (cas_n != '1)));
  // R2: no column strobe outside the row strobe
  p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (rst)
    (cas_n != '1) |-> !ras_n);
  // R2: column address holds while a column strobe is low
  p_col_stable_r2: assert property (@(posedge clk) disable iff (rst)
    ((cas_n != '1) && $past(cas_n != '1)) |-> $stable(dram_addr));
  // R12: an idle block has every strobe released
  p_ready_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ras_n && (cas_n == '1) && we_n));
endmodule

// File: tb/dram_cycle_gen_tb.sv
module dram_cycle_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_ASC = 2, T_WCS = 1, T_CAC = 2, T_AA = 3, T_RAC = 6;
  localparam int T_CWD = 2, T_RWD = 7, T_AWD = 4, T_CWL = 2, T_RP = 3, T_CP = 1;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_ready;
  logic [1:0]  req_kind = 0;
  logic [7:0]  req_addr = 0;
  logic [1:0]  req_be = 0;
  logic [15:0] req_wdata = 0;
  logic        rd_valid, ras_n, we_n, dq_drive, dram_oe;
  logic [15:0] rd_data, dq_out, dq_in = 16'hBAD0;
  logic [1:0]  cas_n;
  logic [3:0]  dram_addr;

  int checks = 0, errors = 0;
  logic [15:0] mem [256];
  logic [15:0] refm [256];
  logic [15:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_gen #(
    .ROW_W(4), .COL_W(4), .LANES(2), .T_ASR(1), .T_RAH(1), .T_ASC(T_ASC),
    .T_WCS(T_WCS), .T_CAC(T_CAC), .T_AA(T_AA), .T_RAC(T_RAC), .T_CWD(T_CWD),
    .T_RWD(T_RWD), .T_AWD(T_AWD), .T_CWL(T_CWL), .T_RP(T_RP), .T_CP(T_CP)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_addr(dram_addr),
    .dq_out(dq_out), .dq_drive(dq_drive), .dq_in(dq_in), .dram_oe(dram_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // memory model and pin timing monitor
  int r_cnt, rp_cnt, c_cnt, cp_cnt, a_cnt, w_cnt, oe_bad, cas_falls;
  int lane_falls [2];
  logic prev_ras, prev_cas, prev_we, wdone, moved, we_seen;
  logic [1:0] prev_lanes;
  logic [3:0] prev_addr, row_l, col_l;
  logic [1:0] cur_kind = 0;
  logic cas_any;
  assign cas_any = (cas_n != 2'b11);

  always @(negedge clk) begin
    if (rst) begin
      r_cnt = 0; rp_cnt = 100; c_cnt = 0; cp_cnt = 100; a_cnt = 0; w_cnt = 0;
      prev_ras = 1; prev_cas = 0; prev_we = 1; prev_lanes = 2'b11;
      prev_addr = 0; wdone = 0; moved = 0; we_seen = 0;
    end else begin
      if (!ras_n && prev_ras) begin
        row_l = dram_addr; we_seen = 0;
        chk(rp_cnt >= T_RP, "R9 row precharge", rp_cnt, T_RP);
      end
      for (int l = 0; l < 2; l++) if (!cas_n[l] && prev_lanes[l]) lane_falls[l]++;
      if (cas_any && !prev_cas) begin
        col_l = dram_addr; moved = 0; cas_falls++;
        chk(a_cnt >= T_ASC, "R2 column setup", a_cnt, T_ASC);
        chk(cp_cnt >= T_CP, "R9 column precharge", cp_cnt, T_CP);
        if (!we_n) begin
          chk(w_cnt >= T_WCS, "R4 write setup", w_cnt, T_WCS);
          chk(dq_drive, "R4 data driven", dq_drive, 1);
        end
      end
      if (!we_n && prev_we && cas_any) begin
        chk(c_cnt >= T_CWD, "R5 cas-to-we", c_cnt, T_CWD);
        chk(r_cnt >= T_RWD, "R5 ras-to-we", r_cnt, T_RWD);
        chk(a_cnt >= T_AWD, "R5 addr-to-we", a_cnt, T_AWD);
      end
      if (!cas_any && prev_cas) begin
        if (!prev_we) chk(w_cnt >= T_CWL, "R6 write lead", w_cnt, T_CWL);
        chk(!moved, "R2 column hold", moved, 0);
        chk(!dram_oe, "R8 oe off at strobe rise", dram_oe, 0);
      end
      if (ras_n && !prev_ras && cur_kind == 2'b00)
        chk(!we_seen, "R7 read keeps we high", we_seen, 0);
      if (cas_any && prev_cas && dram_addr != prev_addr) moved = 1;
      if (!we_n) we_seen = 1;
      if (dram_oe && (ras_n || !cas_any || !we_n)) oe_bad++;
      if (cas_any && !we_n && !wdone) begin
        for (int l = 0; l < 2; l++)
          if (!cas_n[l]) mem[{row_l, col_l}][8*l +: 8] = dq_out[8*l +: 8];
        wdone = 1;
      end
      r_cnt  = ras_n ? 0 : r_cnt + 1;
      rp_cnt = ras_n ? rp_cnt + 1 : 0;
      c_cnt  = cas_any ? c_cnt + 1 : 0;
      cp_cnt = cas_any ? 0 : cp_cnt + 1;
      a_cnt  = (dram_addr != prev_addr) ? 1 : a_cnt + 1;
      w_cnt  = we_n ? 0 : w_cnt + 1;
      if (ras_n) wdone = 0;
      prev_ras = ras_n; prev_cas = cas_any; prev_we = we_n;
      prev_lanes = cas_n; prev_addr = dram_addr;
      dq_in = (cas_any && c_cnt >= T_CAC && r_cnt >= T_RAC && a_cnt >= T_AA)
              ? mem[{row_l, col_l}] : 16'hBAD0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected result", int'(rd_data), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R3/R5/R10/R11 read data", int'(rd_data), int'(e));
      end
    end
  end

  task automatic do_req(input logic [1:0] k, input logic [7:0] a,
                        input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] m;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    m = {{8{be[1]}}, {8{be[0]}}};
    req_valid = 1; req_kind = k; req_addr = a; req_be = be; req_wdata = wd;
    cur_kind = k;
    if (k != 2'b01) exp_q.push_back(refm[a] & m);
    if (k != 2'b00) refm[a] = (refm[a] & ~m) | (wd & m);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R12 busy after accept", req_ready, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic run_tests();
    int f0, f1, cf;
    repeat (3) @(negedge clk);
    chk(ras_n && we_n && cas_n == 2'b11, "R1 strobes in reset", {ras_n, cas_n, we_n}, 15);
    chk(!dram_oe && !rd_valid && req_ready, "R1 idle outputs", {dram_oe, rd_valid, req_ready}, 1);
    rst = 0;
    @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && !dram_oe && req_ready, "R1 after reset",
        {ras_n, cas_n, dram_oe, req_ready}, 29);
    do_req(2'b00, 8'h12, 2'b11, 0);
    do_req(2'b01, 8'h12, 2'b11, 16'hA5C3);
    do_req(2'b00, 8'h12, 2'b11, 0);
    do_req(2'b01, 8'h12, 2'b01, 16'h77FF);   // R10 partial write
    do_req(2'b00, 8'h12, 2'b11, 0);
    do_req(2'b10, 8'h34, 2'b11, 16'h1234);   // R5 old data returned
    do_req(2'b00, 8'h34, 2'b11, 0);
    do_req(2'b10, 8'h56, 2'b10, 16'hBEEF);
    do_req(2'b00, 8'h56, 2'b11, 0);
    wait_idle();
    cf = cas_falls;
    do_req(2'b00, 8'h78, 2'b00, 0);          // R11 no lanes
    do_req(2'b01, 8'h78, 2'b00, 16'hFFFF);
    wait_idle();
    chk(cas_falls == cf, "R11 no column strobe", cas_falls, cf);
    do_req(2'b00, 8'h78, 2'b11, 0);
    wait_idle();
    f0 = lane_falls[0]; f1 = lane_falls[1];
    do_req(2'b00, 8'h9A, 2'b01, 0);
    wait_idle();
    chk(lane_falls[1] == f1, "R10 disabled lane idle", lane_falls[1], f1);
    chk(lane_falls[0] == f0 + 1, "R10 enabled lane strobes", lane_falls[0], f0 + 1);
    do_req(2'b00, 8'hF0, 2'b11, 0);
    do_req(2'b00, 8'h0F, 2'b11, 0);
    do_req(2'b11, 8'hC5, 2'b11, 0);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 every read answered", exp_q.size(), 0);
    chk(oe_bad == 0, "R8 oe only inside strobes", oe_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = {i[7:0], ~i[7:0]};
      refm[i] = {i[7:0], ~i[7:0]};
    end
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule